// File: doc/BRIEF.md
# Packet Modem Receive Task Sequencer

This block runs the receive side of a four-level FSK packet modem. It works in one of two modes, a symbol mode and a binary mode. A controller writes a task code. The block then takes items from an upstream demodulator and decoder and writes the result into a small byte buffer. It also keeps a compact status word. De-interleaving, error correction and checksum evaluation are done upstream. Decoded bytes arrive already corrected, each with a checksum-good flag.

There are two kinds of block task: intermediate and last. During a block task, the item stream carries decoded bytes mixed with channel status items. Status items are taken out of the stream and reported through the status value and status-ready fields. The decoded bytes fill the buffer in arrival order. There are also two raw read tasks. Each one builds a single byte straight from the incoming symbols or bits and places it at buffer address 0.

The controller reads the status word with a read strobe, and the strobe clears the interrupt and status-ready fields. After that, the controller reads buffer bytes through a combinational address port.

Top module: `rx_task_seq`

## Requirements
- R1: After reset, buffer-free is 1, and interrupt, status-ready, status value, checksum-error and valid-count are all 0.
- R2: A task write that is accepted (block idle, legal code) clears buffer-free on the next cycle. Task codes are: 1 = intermediate block, 2 = last block, 3 = raw four symbols (symbol mode only), 4 = raw eight bits (binary mode only).
- R3: In symbol mode, a block task stores 12 decoded bytes (non-status items, in_data) at buffer addresses 0 to 11 in arrival order. It completes only when 12 bytes and 3 status items have been received. On the cycle after the last of these items, buffer-free and interrupt are both 1.
- R4: In symbol mode, when the third status item is the item that completes the block, status-ready and buffer-free go high on the same cycle.
- R5: In binary mode, a block task stores 6 decoded bytes at addresses 0 to 5 and completes on the sixth byte, whatever number of status items has arrived.
- R6: After an intermediate block, the valid-count is 12 (symbol mode) or 6 (binary mode) and checksum-error is 0. After a last block, the valid-count is 8 or 4, and checksum-error is the inverse of in_crc_ok presented with the final stored byte.
- R7: During a block task, each status item (in_status=1) loads the status value on the next cycle, using in_data[1:0] in symbol mode or {0, in_data[0]} in binary mode. It also sets status-ready. It sets interrupt only when stat_irq_en is 1.
- R8: The raw four-symbol task packs the next four items' in_data[1:0], first symbol into bits 7:6. It writes the byte to address 0, sets the valid-count to 1, and sets buffer-free and interrupt.
- R9: The raw eight-bit task packs the next eight items' in_data[0], first bit into bit 7. It does not remove status items (in_status is ignored). It then completes as in R8.
- R10: A status read strobe clears interrupt and status-ready on the next cycle. If a setting event happens in the same cycle, the setting event wins.
- R11: A task write while the block is busy is ignored and does not change the running task.
- R12: An illegal code (0, 5 to 7, or a raw task in the wrong mode) starts no task. The block stays idle with buffer-free still 1, and later items change neither the buffer nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bin | input | 1 | 0 = symbol mode, 1 = binary mode (sampled at task start) |
| stat_irq_en | input | 1 | Status items raise the interrupt when 1 |
| cmd_wr | input | 1 | Task write strobe |
| cmd_code | input | 3 | Task code |
| stat_rd | input | 1 | Status read strobe |
| in_valid | input | 1 | Upstream item valid |
| in_status | input | 1 | Item is a channel status item |
| in_data | input | 8 | Decoded byte, symbol in [1:0] or bit in [0] |
| in_crc_ok | input | 1 | Checksum good, taken with each decoded byte |
| buf_addr | input | 4 | Buffer read address |
| buf_data | output | 8 | Buffer read data |
| stat_bfree | output | 1 | Buffer-free flag |
| stat_irq | output | 1 | Interrupt flag |
| stat_srdy | output | 1 | Status-ready flag |
| stat_sval | output | 2 | Last status value |
| stat_crcerr | output | 1 | Checksum-error flag |
| stat_nvalid | output | 4 | Number of valid buffer bytes |

## Verification
The assertions check several things on every cycle:
- buffer-free drops after an accepted task;
- status-ready and interrupt clear after a read with no new event;
- status-ready rises only after a status item;
- an interrupt without status interrupts enabled comes only with a block completion;
- buffer-free rises only on an input item.

Only the bench scenarios can show the rest:
- buffer contents and byte order;
- the bit packing of the raw tasks;
- the item counts at which blocks complete;
- checksum reporting for last blocks against intermediate blocks;
- that busy and illegal writes leave the buffer untouched.

// File: rtl/rx_task_seq.sv
module rx_task_seq #(
  parameter int NB_SYM   = 12,
  parameter int NB_BIN   = 6,
  parameter int LAST_SYM = 8,
  parameter int LAST_BIN = 4,
  parameter int NST_SYM  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_bin,
  input  logic       stat_irq_en,
  input  logic       cmd_wr,
  input  logic [2:0] cmd_code,
  input  logic       stat_rd,
  input  logic       in_valid,
  input  logic       in_status,
  input  logic [7:0] in_data,
  input  logic       in_crc_ok,
  input  logic [3:0] buf_addr,
  output logic [7:0] buf_data,
  output logic       stat_bfree,
  output logic       stat_irq,
  output logic       stat_srdy,
  output logic [1:0] stat_sval,
  output logic       stat_crcerr,
  output logic [3:0] stat_nvalid
);
  localparam int AW = 4;
  localparam int SW = $clog2(NST_SYM + 1);

  typedef enum logic [1:0] {S_IDLE, S_BLK, S_RAW} st_t;
  st_t st;

  logic [7:0] mem [NB_SYM];
  logic          bin_q, last_q, crc_q;
  logic [AW-1:0] bcnt;
  logic [SW-1:0] scnt;
  logic [7:0]    sh;
  logic [3:0]    rcnt;

  wire legal = (cmd_code == 3'd1) || (cmd_code == 3'd2) ||
               (cmd_code == 3'd3 && !mode_bin) || (cmd_code == 3'd4 && mode_bin);
  wire start = cmd_wr && st == S_IDLE && legal;

  wire [AW-1:0] nb = bin_q ? AW'(NB_BIN) : AW'(NB_SYM);
  wire take_byte = st == S_BLK && in_valid && !in_status && bcnt < nb;
  wire take_stat = st == S_BLK && in_valid && in_status;
  wire [AW-1:0] bcnt_n = bcnt + AW'(take_byte);
  wire [SW-1:0] scnt_n = (take_stat && !bin_q && scnt < SW'(NST_SYM)) ? scnt + 1'b1 : scnt;
  wire blk_done = st == S_BLK && in_valid && bcnt_n == nb && (bin_q || scnt_n == SW'(NST_SYM));

  wire raw_take = st == S_RAW && in_valid;
  wire raw_done = raw_take && rcnt == (bin_q ? 4'd7 : 4'd3);
  wire [7:0] raw_nx = bin_q ? {sh[6:0], in_data[0]} : {sh[5:0], in_data[1:0]};
  wire crc_fin = take_byte ? in_crc_ok : crc_q;

  assign buf_data = (buf_addr < AW'(NB_SYM)) ? mem[buf_addr] : 8'h00;

  always_ff @(posedge clk) begin
    if (take_byte) mem[bcnt] <= in_data;
    else if (raw_done) mem[0] <= raw_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bin_q <= 1'b0;
      last_q <= 1'b0;
      crc_q <= 1'b0;
      bcnt <= '0;
      scnt <= '0;
      sh <= '0;
      rcnt <= '0;
      stat_bfree <= 1'b1;
      stat_irq <= 1'b0;
      stat_srdy <= 1'b0;
      stat_sval <= 2'd0;
      stat_crcerr <= 1'b0;
      stat_nvalid <= '0;
    end else begin
      if (stat_rd) begin
        stat_irq <= 1'b0;
        stat_srdy <= 1'b0;
      end
      if (start) begin
        st <= (cmd_code == 3'd1 || cmd_code == 3'd2) ? S_BLK : S_RAW;
        bin_q <= mode_bin;
        last_q <= cmd_code == 3'd2;
        bcnt <= '0;
        scnt <= '0;
        sh <= '0;
        rcnt <= '0;
        stat_bfree <= 1'b0;
      end
      if (take_byte) begin
        bcnt <= bcnt_n;
        crc_q <= in_crc_ok;
      end
      if (take_stat) begin
        scnt <= scnt_n;
        stat_sval <= bin_q ? {1'b0, in_data[0]} : in_data[1:0];
        stat_srdy <= 1'b1;
        if (stat_irq_en) stat_irq <= 1'b1;
      end
      if (raw_take) begin
        sh <= raw_nx;
        rcnt <= rcnt + 4'd1;
      end
      if (blk_done) begin
        stat_nvalid <= last_q ? (bin_q ? AW'(LAST_BIN) : AW'(LAST_SYM)) : nb;
        stat_crcerr <= last_q && !crc_fin;
      end
      if (raw_done) begin
        stat_nvalid <= AW'(1);
        stat_crcerr <= 1'b0;
      end
      if (blk_done || raw_done) begin
        st <= S_IDLE;
        stat_bfree <= 1'b1;
        stat_irq <= 1'b1;
      end
    end
  end
endmodule

module rx_task_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_bin,
  input logic       stat_irq_en,
  input logic       cmd_wr,
  input logic [2:0] cmd_code,
  input logic       stat_rd,
  input logic       in_valid,
  input logic       in_status,
  input logic       stat_bfree,
  input logic       stat_irq,
  input logic       stat_srdy
);
  wire ok_code = (cmd_code == 3'd1) || (cmd_code == 3'd2) ||
                 (cmd_code == 3'd3 && !mode_bin) || (cmd_code == 3'd4 && mode_bin);

  a_r2_start_clears_bfree: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && stat_bfree && ok_code |=> !stat_bfree);

  a_r10_read_clears_srdy: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !in_valid |=> !stat_srdy);

  a_r10_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !in_valid |=> !stat_irq);

  a_r7_srdy_from_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_srdy) |-> $past(in_valid && in_status));

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_irq) && !$past(stat_irq_en) |-> $rose(stat_bfree));

  a_r3_done_on_item: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_bfree) |-> $past(in_valid));
endmodule

bind rx_task_seq rx_task_seq_chk u_chk (.*);

// File: tb/tb_rx_task_seq.sv
`timescale 1ns/1ps
module tb_rx_task_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_bin = 1'b0, stat_irq_en = 1'b0, cmd_wr = 1'b0, stat_rd = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic       in_valid = 1'b0, in_status = 1'b0, in_crc_ok = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [3:0] buf_addr = 4'd0;
  logic [7:0] buf_data;
  logic       stat_bfree, stat_irq, stat_srdy, stat_crcerr;
  logic [1:0] stat_sval;
  logic [3:0] stat_nvalid;
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rx_task_seq dut (.*);

  localparam logic [7:0] RAW_VEC [6] = '{8'hB4, 8'h1E, 8'hFF, 8'h00, 8'h6C, 8'h93};

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] c);
    cmd_wr = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic item(input logic s, input logic [7:0] d, input logic crc);
    in_valid = 1'b1; in_status = s; in_data = d; in_crc_ok = crc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic chk_buf(input string req, input int a, input int exp);
    buf_addr = 4'(a);
    #0.5;
    chk(req, $sformatf("buf[%0d]", a), buf_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", "bfree", stat_bfree, 1);
    chk("R1", "irq", stat_irq, 0);
    chk("R1", "srdy", stat_srdy, 0);
    chk("R1", "sval", stat_sval, 0);
    chk("R1", "crcerr", stat_crcerr, 0);
    chk("R1", "nvalid", stat_nvalid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 raw four-symbol table
    mode_bin = 1'b0;
    for (int v = 0; v < 6; v++) begin
      cmd(3'd3);
      if (v == 0) chk("R2", "bfree after start", stat_bfree, 0);
      for (int k = 3; k >= 0; k--) item(k[0], {6'b101010, RAW_VEC[v][2*k+1 -: 2]}, 1'b0);
      chk("R8", "bfree", stat_bfree, 1);
      chk("R8", "irq", stat_irq, 1);
      chk("R8", "nvalid", stat_nvalid, 1);
      chk_buf("R8", 0, RAW_VEC[v]);
      rd_stat();
    end

    // R9 raw eight-bit table, status flag ignored
    mode_bin = 1'b1;
    for (int v = 0; v < 6; v++) begin
      cmd(3'd4);
      for (int k = 7; k >= 0; k--) item(k[0], {7'b0101010, RAW_VEC[5-v][k]}, 1'b0);
      chk("R9", "bfree", stat_bfree, 1);
      chk("R9", "srdy untouched", stat_srdy, 0);
      chk_buf("R9", 0, RAW_VEC[5-v]);
      rd_stat();
    end

    // symbol intermediate block with interleaved status
    mode_bin = 1'b0; stat_irq_en = 1'b0;
    cmd(3'd1);
    item(1'b1, 8'h02, 1'b0);
    chk("R7", "srdy", stat_srdy, 1);
    chk("R7", "sval", stat_sval, 2);
    chk("R7", "irq disabled", stat_irq, 0);
    cmd(3'd2);  // R11 busy write ignored
    for (int i = 0; i < 4; i++) item(1'b0, 8'(8'h30 + 7 * i), 1'b1);
    item(1'b1, 8'h01, 1'b0);
    for (int i = 4; i < 12; i++) item(1'b0, 8'(8'h30 + 7 * i), 1'b1);
    chk("R3", "bfree before 3rd status", stat_bfree, 0);
    rd_stat();
    chk("R10", "srdy cleared", stat_srdy, 0);
    item(1'b1, 8'h03, 1'b0);
    chk("R4", "srdy with bfree", stat_srdy, 1);
    chk("R4", "bfree with srdy", stat_bfree, 1);
    chk("R3", "irq", stat_irq, 1);
    chk("R7", "sval", stat_sval, 3);
    chk("R11", "nvalid stays intermediate", stat_nvalid, 12);
    chk("R6", "crcerr intermediate", stat_crcerr, 0);
    for (int i = 0; i < 12; i++) chk_buf("R3", i, 8'(8'h30 + 7 * i));
    rd_stat();
    chk("R10", "irq cleared", stat_irq, 0);

    // binary last block, status interrupts on, read collides with status
    mode_bin = 1'b1; stat_irq_en = 1'b1;
    cmd(3'd2);
    item(1'b0, 8'hA0, 1'b1);
    stat_rd = 1'b1;
    item(1'b1, 8'hFF, 1'b0);
    stat_rd = 1'b0;
    chk("R10", "set wins srdy", stat_srdy, 1);
    chk("R7", "irq enabled", stat_irq, 1);
    chk("R7", "sval binary", stat_sval, 1);
    for (int i = 1; i < 6; i++) item(1'b0, 8'(8'hA0 + i), i != 5);
    chk("R5", "bfree", stat_bfree, 1);
    chk("R6", "nvalid last bin", stat_nvalid, 4);
    chk("R6", "crcerr last", stat_crcerr, 1);
    for (int i = 0; i < 6; i++) chk_buf("R5", i, 8'(8'hA0 + i));
    rd_stat();

    // symbol last block, checksum good
    mode_bin = 1'b0; stat_irq_en = 1'b0;
    cmd(3'd2);
    for (int i = 0; i < 3; i++) item(1'b1, 8'(i), 1'b0);
    for (int i = 0; i < 12; i++) item(1'b0, 8'(8'h50 + i), 1'b1);
    chk("R6", "nvalid last sym", stat_nvalid, 8);
    chk("R6", "crcerr good", stat_crcerr, 0);
    chk_buf("R3", 11, 8'h5B);
    rd_stat();

    // R12 illegal codes
    cmd(3'd4);
    chk("R12", "bfree wrong-mode raw", stat_bfree, 1);
    cmd(3'd7);
    chk("R12", "bfree code 7", stat_bfree, 1);
    for (int i = 0; i < 4; i++) item(i[0], 8'hEE, 1'b0);
    chk("R12", "nvalid unchanged", stat_nvalid, 8);
    chk("R12", "srdy unchanged", stat_srdy, 0);
    chk("R12", "irq unchanged", stat_irq, 0);
    chk_buf("R12", 0, 8'h50);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule